// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Block Refill

This block is a read-only instruction cache placed between a processor fetch port and a slower memory that returns one 32-bit word per transfer. It has four lines, each holding an aligned group of four words. Every fetch byte address is cut into fields: the lowest bits pick a byte, the next two pick a word inside the line, the next two pick the line, and everything above forms the tag. A fetch that finds a valid line with a matching tag is answered one cycle later with the selected word, and memory is not touched.

A fetch that misses stalls the fetch port. The block then reads the four words of the aligned group from memory in ascending order, one request/acknowledge transfer per word, each with any latency. It writes each word into the line as it arrives and overwrites whatever the line held before. With the last word it stores the new tag and marks the line valid, and in the next cycle it returns the word that was asked for. Three running counters report accepted fetches, hits and misses.

Top module: `icache_dm_top`

## Requirements
- R1: A fetch address splits as byte offset bits [1:0] (ignored for the lookup), word select bits [3:2], line select bits [5:4] and tag bits [63:6]; the response is the 32-bit word at byte address {addr[63:2], 2'b00}.
- R2: A fetch hits only when the selected line is valid and its stored tag equals the full address tag; a hit raises rsp_valid with the word in the cycle after acceptance and issues no memory request.
- R3: After reset every line is invalid, the counters are zero, fetch_ready is 1 and rsp_valid and mem_req are 0; the first fetch of any address, address 0 included, misses.
- R4: A miss reads exactly the four words at byte addresses base, base+4, base+8 and base+12 (base = addr with bits [3:0] cleared), in that order; mem_req and mem_addr hold steady until mem_ack, and mem_addr is always word aligned.
- R5: fetch_ready is 0 from the cycle after a missing fetch is accepted until the last memory word is acknowledged; the response comes in the cycle after that acknowledge, when fetch_ready is 1 again.
- R6: A miss overwrites the selected line whatever it held, so two addresses with the same line select and different tags evict each other.
- R7: cnt_refs counts accepted fetches (fetch_req and fetch_ready high at a clock edge), cnt_hits counts hits, cnt_misses counts misses, and cnt_refs equals cnt_hits plus cnt_misses at all times.
- R8: A sequential fetch stream through an aligned four-word group that is not yet present gives one miss followed by three hits.
- R9: fetch_req while fetch_ready is 0 is ignored: it is not counted, gets no response and starts no memory read.
- R10: Each accepted fetch produces exactly one single-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 64 | Fetch byte address |
| fetch_ready | output | 1 | Fetch port can accept a request |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_data | output | 32 | Response word |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 64 | Memory word byte address |
| mem_ack | input | 1 | Memory acknowledge; mem_data valid |
| mem_data | input | 32 | Memory read word |
| cnt_refs | output | 32 | Accepted fetch count |
| cnt_hits | output | 32 | Hit count |
| cnt_misses | output | 32 | Miss count |

## Verification
The fetch patterns are a cold fetch of address 0, which shows that a zeroed line does not hit falsely, and a sequential walk through several groups, which shows the miss-then-three-hits rhythm. Other patterns are an alternation of two addresses sharing a line, which separates an overwrite on miss from a stale hit, and a pair differing only in the highest tag bits, which catches a truncated tag compare. Further patterns are a mid-group first fetch and byte-offset variants, which check word selection during refill, and fetch requests held high during a refill, which must be ignored. A long pseudo-random stream over a small region, with memory latencies from zero to three cycles, is compared every clock against a behavioural model of the lines and counters.

// File: rtl/icache_pkg.sv
package icache_pkg;

    // Refill sequencer state
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

    // Per-cycle counter events
    typedef struct packed {
        logic ref_evt;
        logic hit_evt;
        logic miss_evt;
    } cnt_evt_t;

    // Number of bits needed to index n items (at least 1)
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
    parameter int SLOTS = 4,
    parameter int TAG_W = 58,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [SLOTS-1:0] valid_vec;
    logic [TAG_W-1:0] tag_arr [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_line
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= wr_tag;
            end
        end

        assign valid_vec[s] = v_q;
        assign tag_arr[s]   = t_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int SLOTS       = 4,
    parameter int BLOCK_WORDS = 4,
    parameter int WORD_W      = 32,
    parameter int IDX_W       = 2,
    parameter int WOFF_W      = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WOFF_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data
);

    localparam int DEPTH = SLOTS * BLOCK_WORDS;
    localparam int AW    = IDX_W + WOFF_W;

    logic [WORD_W-1:0] words_q [DEPTH];
    logic [AW-1:0]     wr_pos;
    logic [AW-1:0]     rd_pos;

    assign wr_pos = {wr_idx, wr_word};
    assign rd_pos = {rd_idx, rd_word};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_pos] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_pos];

endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int WORD_W      = 32,
    parameter int BLOCK_WORDS = 4,
    parameter int TAG_W       = 58,
    parameter int IDX_W       = 2,
    parameter int WOFF_W      = 2,
    parameter int OFF_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [WOFF_W-1:0] start_woff,
    output logic              idle,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WOFF_W-1:0] wr_word,
    output logic [WORD_W-1:0] wr_data,
    output logic              commit,
    output logic [TAG_W-1:0]  commit_tag,
    output logic [WORD_W-1:0] done_data
);

    localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(BLOCK_WORDS - 1);

    fill_state_e       state_q;
    logic [WOFF_W-1:0] beat_q;
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WOFF_W-1:0] woff_q;
    logic [WORD_W-1:0] grab_q;
    logic              beat_done;
    logic              last_beat;

    assign beat_done = (state_q == FILL_BUSY) && mem_ack;
    assign last_beat = (beat_q == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_IDLE;
            beat_q  <= '0;
        end else begin
            unique case (state_q)
                FILL_IDLE: begin
                    if (start) begin
                        state_q <= FILL_BUSY;
                        beat_q  <= '0;
                    end
                end
                FILL_BUSY: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            state_q <= FILL_IDLE;
                        end
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    // Miss context captured at the start of a refill
    always_ff @(posedge clk) begin
        if (state_q == FILL_IDLE && start) begin
            tag_q  <= start_tag;
            idx_q  <= start_idx;
            woff_q <= start_woff;
        end
    end

    // Keep the requested word when its beat passes by
    always_ff @(posedge clk) begin
        if (beat_done && (beat_q == woff_q)) begin
            grab_q <= mem_data;
        end
    end

    assign idle       = (state_q == FILL_IDLE);
    assign mem_req    = (state_q == FILL_BUSY);
    assign mem_addr   = {tag_q, idx_q, beat_q, {OFF_W{1'b0}}};

    assign wr_en      = beat_done;
    assign wr_idx     = idx_q;
    assign wr_word    = beat_q;
    assign wr_data    = mem_data;

    assign commit     = beat_done && last_beat;
    assign commit_tag = tag_q;
    assign done_data  = (beat_q == woff_q) ? mem_data : grab_q;

endmodule

// File: rtl/icache_dm_top.sv
module icache_dm_top
    import icache_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int WORD_W      = 32,
    parameter int SLOTS       = 4,
    parameter int BLOCK_WORDS = 4,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_data,
    output logic [CNT_W-1:0]  cnt_refs,
    output logic [CNT_W-1:0]  cnt_hits,
    output logic [CNT_W-1:0]  cnt_misses
);

    localparam int OFF_W   = idx_bits(WORD_W / 8);
    localparam int WOFF_W  = idx_bits(BLOCK_WORDS);
    localparam int IDX_W   = idx_bits(SLOTS);
    localparam int TAG_LSB = OFF_W + WOFF_W + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    // Address fields (R1)
    logic [WOFF_W-1:0] a_woff;
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;

    assign a_woff = fetch_addr[OFF_W +: WOFF_W];
    assign a_idx  = fetch_addr[OFF_W + WOFF_W +: IDX_W];
    assign a_tag  = fetch_addr[ADDR_W-1:TAG_LSB];

    logic              idle;
    logic              accept;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [WORD_W-1:0] line_word;
    logic              lookup_hit;
    cnt_evt_t          evt;

    logic              dwr_en;
    logic [IDX_W-1:0]  dwr_idx;
    logic [WOFF_W-1:0] dwr_word;
    logic [WORD_W-1:0] dwr_data;
    logic              commit;
    logic [TAG_W-1:0]  commit_tag;
    logic [WORD_W-1:0] done_data;

    assign fetch_ready = idle;
    assign accept      = fetch_req && idle;
    assign lookup_hit  = line_valid && (line_tag == a_tag);

    always_comb begin
        evt.ref_evt  = accept;
        evt.hit_evt  = accept && lookup_hit;
        evt.miss_evt = accept && !lookup_hit;
    end

    icache_tag_store #(
        .SLOTS (SLOTS),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) tags_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (a_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (commit),
        .wr_idx   (dwr_idx),
        .wr_tag   (commit_tag)
    );

    icache_data_store #(
        .SLOTS       (SLOTS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .WORD_W      (WORD_W),
        .IDX_W       (IDX_W),
        .WOFF_W      (WOFF_W)
    ) data_i (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_word (a_woff),
        .rd_data (line_word),
        .wr_en   (dwr_en),
        .wr_idx  (dwr_idx),
        .wr_word (dwr_word),
        .wr_data (dwr_data)
    );

    icache_refill_ctrl #(
        .ADDR_W      (ADDR_W),
        .WORD_W      (WORD_W),
        .BLOCK_WORDS (BLOCK_WORDS),
        .TAG_W       (TAG_W),
        .IDX_W       (IDX_W),
        .WOFF_W      (WOFF_W),
        .OFF_W       (OFF_W)
    ) fill_i (
        .clk        (clk),
        .rst        (rst),
        .start      (evt.miss_evt),
        .start_tag  (a_tag),
        .start_idx  (a_idx),
        .start_woff (a_woff),
        .idle       (idle),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_data   (mem_data),
        .wr_en      (dwr_en),
        .wr_idx     (dwr_idx),
        .wr_word    (dwr_word),
        .wr_data    (dwr_data),
        .commit     (commit),
        .commit_tag (commit_tag),
        .done_data  (done_data)
    );

    // Response register: a hit answers next cycle, a refill answers after its last beat
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= evt.hit_evt || commit;
            if (evt.hit_evt) begin
                rsp_data <= line_word;
            end else if (commit) begin
                rsp_data <= done_data;
            end
        end
    end

    // Reference, hit and miss counters
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_refs   <= '0;
            cnt_hits   <= '0;
            cnt_misses <= '0;
        end else begin
            if (evt.ref_evt)  cnt_refs   <= cnt_refs + 1'b1;
            if (evt.hit_evt)  cnt_hits   <= cnt_hits + 1'b1;
            if (evt.miss_evt) cnt_misses <= cnt_misses + 1'b1;
        end
    end

endmodule

// File: rtl/icache_dm_chk.sv
module icache_dm_chk #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              fetch_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [CNT_W-1:0]  cnt_refs,
    input logic [CNT_W-1:0]  cnt_hits,
    input logic [CNT_W-1:0]  cnt_misses
);

    logic is_last_beat;
    assign is_last_beat = (mem_addr[3:2] == 2'b11);

    assert_cnt_sum_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_refs == cnt_hits + cnt_misses);

    assert_refs_step_R7: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_ready) |=> cnt_refs == $past(cnt_refs) + 1'b1);

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !(fetch_req && fetch_ready) |=> $stable(cnt_refs));

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_mem_align_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_beat_order_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !is_last_beat) |=> (mem_req && mem_addr == $past(mem_addr) + 4));

    assert_busy_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !fetch_ready);

    assert_rsp_after_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && is_last_beat) |=> (rsp_valid && fetch_ready && !mem_req));

    assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_ready && !mem_req) |=> (rsp_valid != mem_req));

endmodule

bind icache_dm_top icache_dm_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .fetch_req   (fetch_req),
    .fetch_ready (fetch_ready),
    .rsp_valid   (rsp_valid),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .cnt_refs    (cnt_refs),
    .cnt_hits    (cnt_hits),
    .cnt_misses  (cnt_misses)
);

// File: tb/icache_dm_top_tb_top.sv
`timescale 1ns/1ps
module icache_dm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [63:0] fetch_addr = '0;
    logic        fetch_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;
    logic [31:0] cnt_refs, cnt_hits, cnt_misses;

    always #10 clk = ~clk;  // 50 MHz

    icache_dm_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_ready (fetch_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_data    (mem_data),
        .cnt_refs    (cnt_refs),
        .cnt_hits    (cnt_hits),
        .cnt_misses  (cnt_misses)
    );

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    // Behavioural reference model
    bit          ref_valid [4];
    logic [57:0] ref_tag   [4];
    int          m_refs = 0, m_hits = 0, m_misses = 0;
    logic [63:0] memq [$];

    function automatic logic [31:0] memf(input logic [63:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Memory responder: latency 0..3 cycles per beat
    int lat = 0;
    int lat_seed = 1;
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                lat_seed = lat_seed + 3;
                lat = lat_seed % 4;
            end else if (mem_req) begin
                if (lat == 0) begin
                    mem_ack  = 1'b1;
                    mem_data = memf(mem_addr);
                end else begin
                    lat--;
                end
            end
        end
    end

    // Record every acknowledged memory read
    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) memq.push_back(mem_addr);
    end

    // Per-cycle comparison of counters against the model (R7)
    always @(posedge clk) begin
        #5;
        if (running && !rst) begin
            chk(cnt_refs == 32'(m_refs), "R7", "cnt_refs", 64'(cnt_refs), 64'(m_refs));
            chk(cnt_hits == 32'(m_hits), "R7", "cnt_hits", 64'(cnt_hits), 64'(m_hits));
            chk(cnt_misses == 32'(m_misses), "R7", "cnt_misses", 64'(cnt_misses), 64'(m_misses));
        end
    end

    task automatic fetch(input logic [63:0] a, input string rq, input bit noisy);
        logic [1:0]  idx;
        logic [57:0] tg;
        logic [31:0] exp;
        logic [63:0] base;
        bit          eh;
        int          waitc;
        while (!fetch_ready) @(negedge clk);
        idx  = a[5:4];
        tg   = a[63:6];
        exp  = memf({a[63:2], 2'b00});
        base = {a[63:4], 4'b0000};
        eh   = ref_valid[idx] && (ref_tag[idx] == tg);
        memq.delete();
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(posedge clk);
        m_refs++;
        if (eh) m_hits++;
        else begin
            m_misses++;
            ref_valid[idx] = 1'b1;
            ref_tag[idx]   = tg;
        end
        @(negedge clk);
        fetch_req = 1'b0;
        if (eh) begin
            chk(rsp_valid == 1'b1, rq, "hit response next cycle", 64'(rsp_valid), 64'd1);
            chk(rsp_data == exp, rq, "hit word", 64'(rsp_data), 64'(exp));
            chk(memq.size() == 0 && !mem_req, "R2", "hit issued memory read", 64'(memq.size()), 64'd0);
        end else begin
            chk(rsp_valid == 1'b0 && fetch_ready == 1'b0, "R5", "miss must stall",
                {62'd0, rsp_valid, fetch_ready}, 64'd0);
            waitc = 0;
            while (!rsp_valid && waitc < 200) begin
                if (noisy) begin
                    fetch_req  = 1'b1;
                    fetch_addr = a ^ 64'h0000_0000_0000_1230;
                end
                @(negedge clk);
                waitc++;
            end
            fetch_req = 1'b0;
            chk(rsp_valid == 1'b1, rq, "miss response arrives", 64'(rsp_valid), 64'd1);
            chk(rsp_data == exp, rq, "refilled word", 64'(rsp_data), 64'(exp));
            chk(fetch_ready == 1'b1, "R5", "ready with response", 64'(fetch_ready), 64'd1);
            chk(memq.size() == 4, "R4", "beat count", 64'(memq.size()), 64'd4);
            for (int i = 0; i < 4 && i < memq.size(); i++) begin
                chk(memq[i] == base + 64'(4 * i), "R4", "beat address", memq[i], base + 64'(4 * i));
            end
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "single response pulse", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        int h0, m0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3: reset state
        chk(cnt_refs == 0 && cnt_hits == 0 && cnt_misses == 0, "R3", "counters zero",
            64'(cnt_refs), 64'd0);
        chk(fetch_ready == 1'b1, "R3", "ready after reset", 64'(fetch_ready), 64'd1);
        chk(rsp_valid == 1'b0 && mem_req == 1'b0, "R3", "quiet after reset",
            {62'd0, rsp_valid, mem_req}, 64'd0);
        running = 1'b1;

        // R3: address 0 must miss on an empty cache; R8 first group
        fetch(64'h0, "R3", 1'b0);
        chk(cnt_misses == 1, "R3", "address 0 missed", 64'(cnt_misses), 64'd1);
        fetch(64'h4, "R8", 1'b0);
        fetch(64'h8, "R8", 1'b0);
        fetch(64'hC, "R8", 1'b0);

        // R8: sequential walk through three more groups
        h0 = int'(cnt_hits);
        m0 = int'(cnt_misses);
        for (int w = 4; w < 16; w++) fetch(64'(w * 4), "R8", 1'b0);
        chk(int'(cnt_misses) - m0 == 3, "R8", "misses in sequential walk", 64'(int'(cnt_misses) - m0), 64'd3);
        chk(int'(cnt_hits) - h0 == 9, "R8", "hits in sequential walk", 64'(int'(cnt_hits) - h0), 64'd9);

        // R1: mid-group first fetch, byte offset ignored
        fetch(64'h48, "R1", 1'b0);
        fetch(64'h40, "R1", 1'b0);
        fetch(64'h43, "R1", 1'b0);
        fetch(64'h4D, "R1", 1'b0);

        // R6: conflicting tags in line 0 evict each other
        fetch(64'h00, "R6", 1'b0);
        fetch(64'h40, "R6", 1'b0);
        fetch(64'h00, "R6", 1'b0);
        fetch(64'h44, "R6", 1'b0);

        // R2/R1: tags differing only in high bits
        fetch(64'h10, "R2", 1'b0);
        fetch(64'h8000_0000_0000_0010, "R2", 1'b0);
        fetch(64'h10, "R2", 1'b0);
        fetch(64'h8000_0000_0000_0014, "R2", 1'b0);

        // R9: requests during a refill are ignored
        fetch(64'h1F0, "R9", 1'b1);
        fetch(64'h3F4, "R9", 1'b1);
        fetch(64'h1F8, "R9", 1'b0);

        // Pseudo-random stream over a small region
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a;
            a = 64'(((i * 53 + 7) % 128) * 4) | 64'(i % 4);
            if (i % 17 == 0) a = a | 64'h0000_0100_0000_0000;
            fetch(a, "R2", (i % 11) == 0);
        end

        @(negedge clk);
        running = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule